// File: doc/BRIEF.md
# Serial-Probe Pseudo-Associative Cache

This block is a small cache whose storage is a single direct-mapped array of lines. The array is read as a set-associative structure by walking through it. The line index space is split into a way field (the high index bits) and a set field (the low index bits). A lookup visits one candidate line per clock. It starts with way 0 of the addressed set and moves up to the last way. The walk ends at the first line whose valid bit is set and whose stored tag equals the request tag. Because of this, a line that sits in a low way is found sooner than one in a high way.

A request is accepted while the block is idle, and the block handles one request at a time. A read that misses in every way fetches the line from the next level through a simple request/acknowledge pair. The line goes into the first empty way of the set. When the set has no empty way, a per-set rotating pointer picks the victim. Writes always pass through to the next level. A write updates the cache only when it hits, and a write miss leaves the array unchanged. Each response reports hit or miss and the number of probes the lookup used, so software models and performance counters can see the cost of every access.

Top module: `serial_probe_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `mem_rd_valid` and `mem_wr_valid` are 0. Every line is invalid, so the first read of any address misses.
- R2: The set is `req_addr[OFF_W +: SET_W]` and the tag is every address bit above the set field. Probe number i reads array line `{i, set}`.
- R3: Probes run one per cycle in the order 0, 1, …, WAYS-1 and stop at the first match. A hit in way i reports `rsp_probes` = i+1 and raises `rsp_valid` i+1 clock edges after the accepting edge.
- R4: A read hit returns the data stored in the matching line on `rsp_rdata` with `rsp_hit` = 1.
- R5: A read that misses in all ways reports `rsp_hit` = 0 and `rsp_probes` = WAYS. It holds `mem_rd_valid` with the line address (offset bits zero) on `mem_rd_addr` until `mem_rd_ack`, then returns `mem_rd_data` on `rsp_rdata`.
- R6: A read miss fills the lowest-numbered way of the set whose line is invalid.
- R7: When all ways of the set are valid, the fill goes to the way named by that set's rotating pointer. The pointer then moves on by one modulo WAYS, and the pointers of other sets are left alone.
- R8: A write hit replaces the data of the matching line and reports `rsp_hit` = 1. In the response cycle it pulses `mem_wr_valid` with the full request address and the write data.
- R9: A write miss reports `rsp_hit` = 0 and `rsp_probes` = WAYS and issues the same write-through pulse. It never raises `mem_rd_valid` and allocates no line, so a later read of that address misses.
- R10: `req_ready` is 1 only while idle, and `rsp_valid` is a single-cycle pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Lookup found the line |
| rsp_rdata | output | DATA_W | Read data (reads only) |
| rsp_probes | output | $clog2(WAYS+1) | Number of probes the lookup used |
| mem_rd_valid | output | 1 | Line fetch request to next level |
| mem_rd_addr | output | ADDR_W | Line-aligned fetch address |
| mem_rd_ack | input | 1 | Fetch data valid this cycle |
| mem_rd_data | input | DATA_W | Fetched line |
| mem_wr_valid | output | 1 | Write-through pulse |
| mem_wr_addr | output | ADDR_W | Write-through address |
| mem_wr_data | output | DATA_W | Write-through data |

## Verification
The bench builds the block with its defaults: a 12-bit address, 2 offset bits, 16 lines and 4 ways, which gives 4 sets and an 8-bit tag. Random traffic draws six tags per set, two more than the number of ways. This forces frequent round-robin evictions, hits at every probe depth from 1 to 4, and write hits and misses that land on both resident and evicted lines. Fetch latency varies from 0 to 3 cycles, so the hold of a pending fetch is exercised too.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_FILL  = 2'd2,
        ST_DONE  = 2'd3
    } spc_state_e;

endpackage

// File: rtl/spc_store.sv
module spc_store #(
    parameter int LINES  = 16,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);

    typedef struct {
        logic [LINES-1:0]  valid;
        logic [TAG_W-1:0]  tag  [LINES];
        logic [DATA_W-1:0] data [LINES];
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.valid[wr_idx] = 1'b1;
            s_d.tag[wr_idx]   = wr_tag;
            s_d.data[wr_idx]  = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.valid <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_valid = s_q.valid[rd_idx];
    assign rd_tag   = s_q.tag[rd_idx];
    assign rd_data  = s_q.data[rd_idx];

    // R1: no line may be valid in the first cycle after reset
    p_clear_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (s_q.valid == '0));

endmodule

// File: rtl/spc_victim.sv
module spc_victim #(
    parameter int SETS = 4,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_i,
    input  logic             adv_i,
    output logic [WAY_W-1:0] way_o
);

    logic [SETS-1:0][WAY_W-1:0] rr_d, rr_q;

    always_comb begin
        rr_d = rr_q;
        if (adv_i) begin
            rr_d[set_i] = rr_q[set_i] + WAY_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else begin
            rr_q <= rr_d;
        end
    end

    assign way_o = rr_q[set_i];

    // R7: pointers only move when a replacement consumes one
    p_rr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(rr_q));

endmodule

// File: rtl/spc_ctrl.sv
module spc_ctrl
    import spc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2,
    parameter int SET_W  = 2,
    parameter int WAYS   = 4,
    localparam int WAY_W = $clog2(WAYS),
    localparam int IDX_W = WAY_W + SET_W,
    localparam int TAG_W = ADDR_W - OFF_W - SET_W,
    localparam int PRB_W = $clog2(WAYS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [PRB_W-1:0]  rsp_probes,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ack,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic [IDX_W-1:0]  st_rd_idx,
    input  logic              st_rd_valid,
    input  logic [TAG_W-1:0]  st_rd_tag,
    input  logic [DATA_W-1:0] st_rd_data,
    output logic              st_wr_en,
    output logic [IDX_W-1:0]  st_wr_idx,
    output logic [TAG_W-1:0]  st_wr_tag,
    output logic [DATA_W-1:0] st_wr_data,
    output logic [SET_W-1:0]  vic_set,
    output logic              vic_adv,
    input  logic [WAY_W-1:0]  vic_way
);

    typedef struct packed {
        spc_state_e        st;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [WAY_W-1:0]  probe;
        logic              inv_found;
        logic [WAY_W-1:0]  inv_way;
        logic              hit;
        logic [DATA_W-1:0] rdata;
        logic [PRB_W-1:0]  probes;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic [TAG_W-1:0]  tag_q;
    logic [SET_W-1:0]  set_q;
    logic              hit_now;
    logic              last_probe;
    logic [WAY_W-1:0]  fill_way;
    logic [ADDR_W-1:0] line_addr;

    assign tag_q      = c_q.addr[ADDR_W-1 -: TAG_W];
    assign set_q      = c_q.addr[OFF_W +: SET_W];
    assign st_rd_idx  = {c_q.probe, set_q};
    assign hit_now    = st_rd_valid && (st_rd_tag == tag_q);
    assign last_probe = (c_q.probe == WAY_W'(WAYS - 1));
    assign fill_way   = c_q.inv_found ? c_q.inv_way : vic_way;
    assign line_addr  = {tag_q, set_q, {OFF_W{1'b0}}};
    assign vic_set    = set_q;

    always_comb begin
        c_d        = c_q;
        st_wr_en   = 1'b0;
        st_wr_idx  = st_rd_idx;
        st_wr_tag  = tag_q;
        st_wr_data = c_q.wdata;
        vic_adv    = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    c_d.st        = ST_PROBE;
                    c_d.wr        = req_write;
                    c_d.addr      = req_addr;
                    c_d.wdata     = req_wdata;
                    c_d.probe     = '0;
                    c_d.inv_found = 1'b0;
                    c_d.inv_way   = '0;
                end
            end
            ST_PROBE: begin
                if (hit_now) begin
                    c_d.st     = ST_DONE;
                    c_d.hit    = 1'b1;
                    c_d.probes = PRB_W'(c_q.probe) + PRB_W'(1);
                    c_d.rdata  = c_q.wr ? '0 : st_rd_data;
                    st_wr_en   = c_q.wr;
                end else begin
                    if (!st_rd_valid && !c_q.inv_found) begin
                        c_d.inv_found = 1'b1;
                        c_d.inv_way   = c_q.probe;
                    end
                    if (last_probe) begin
                        c_d.hit    = 1'b0;
                        c_d.probes = PRB_W'(WAYS);
                        c_d.rdata  = '0;
                        c_d.st     = c_q.wr ? ST_DONE : ST_FILL;
                    end else begin
                        c_d.probe = c_q.probe + WAY_W'(1);
                    end
                end
            end
            ST_FILL: begin
                if (mem_rd_ack) begin
                    st_wr_en   = 1'b1;
                    st_wr_idx  = {fill_way, set_q};
                    st_wr_data = mem_rd_data;
                    vic_adv    = !c_q.inv_found;
                    c_d.rdata  = mem_rd_data;
                    c_d.st     = ST_DONE;
                end
            end
            ST_DONE: begin
                c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign req_ready    = (c_q.st == ST_IDLE);
    assign rsp_valid    = (c_q.st == ST_DONE);
    assign rsp_hit      = c_q.hit;
    assign rsp_rdata    = c_q.rdata;
    assign rsp_probes   = c_q.probes;
    assign mem_rd_valid = (c_q.st == ST_FILL);
    assign mem_rd_addr  = line_addr;
    assign mem_wr_valid = (c_q.st == ST_DONE) && c_q.wr;
    assign mem_wr_addr  = c_q.addr;
    assign mem_wr_data  = c_q.wdata;

    // R10: one response pulse, never together with readiness
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    // R3: probe count stays within the way range
    p_probe_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_probes != '0) && (rsp_probes <= PRB_W'(WAYS)));
    // R3: a missed non-final probe is followed by the next way
    p_probe_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_PROBE) && !hit_now && !last_probe
        |=> (c_q.st == ST_PROBE) && (c_q.probe == $past(c_q.probe) + WAY_W'(1)));
    // R5: a miss has tried every way
    p_miss_all_ways_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_hit |-> rsp_probes == PRB_W'(WAYS));
    // R5: a pending fetch holds its address until acknowledged
    p_fetch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ack |=> mem_rd_valid && $stable(mem_rd_addr));
    // R9: writes never fetch
    p_write_no_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !c_q.wr);
    // R8: write-through only alongside a response
    p_wt_with_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> rsp_valid);
    // R7: the pointer advances only when the set had no empty way
    p_adv_only_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vic_adv |-> !c_q.inv_found && mem_rd_valid);

endmodule

// File: rtl/serial_probe_cache.sv
module serial_probe_cache #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2,
    parameter int LINES  = 16,
    parameter int WAYS   = 4,
    localparam int SETS  = LINES / WAYS,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - OFF_W - SET_W,
    localparam int PRB_W = $clog2(WAYS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [PRB_W-1:0]  rsp_probes,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ack,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);

    logic [IDX_W-1:0]  st_rd_idx;
    logic              st_rd_valid;
    logic [TAG_W-1:0]  st_rd_tag;
    logic [DATA_W-1:0] st_rd_data;
    logic              st_wr_en;
    logic [IDX_W-1:0]  st_wr_idx;
    logic [TAG_W-1:0]  st_wr_tag;
    logic [DATA_W-1:0] st_wr_data;
    logic [SET_W-1:0]  vic_set;
    logic              vic_adv;
    logic [WAY_W-1:0]  vic_way;

    spc_store #(
        .LINES (LINES),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (st_rd_idx),
        .rd_valid(st_rd_valid),
        .rd_tag  (st_rd_tag),
        .rd_data (st_rd_data),
        .wr_en   (st_wr_en),
        .wr_idx  (st_wr_idx),
        .wr_tag  (st_wr_tag),
        .wr_data (st_wr_data)
    );

    spc_victim #(
        .SETS(SETS),
        .WAYS(WAYS)
    ) u_victim (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(vic_set),
        .adv_i(vic_adv),
        .way_o(vic_way)
    );

    spc_ctrl #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .OFF_W (OFF_W),
        .SET_W (SET_W),
        .WAYS  (WAYS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_hit     (rsp_hit),
        .rsp_rdata   (rsp_rdata),
        .rsp_probes  (rsp_probes),
        .mem_rd_valid(mem_rd_valid),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_ack  (mem_rd_ack),
        .mem_rd_data (mem_rd_data),
        .mem_wr_valid(mem_wr_valid),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data),
        .st_rd_idx   (st_rd_idx),
        .st_rd_valid (st_rd_valid),
        .st_rd_tag   (st_rd_tag),
        .st_rd_data  (st_rd_data),
        .st_wr_en    (st_wr_en),
        .st_wr_idx   (st_wr_idx),
        .st_wr_tag   (st_wr_tag),
        .st_wr_data  (st_wr_data),
        .vic_set     (vic_set),
        .vic_adv     (vic_adv),
        .vic_way     (vic_way)
    );

endmodule

// File: tb/test_serial_probe_cache.sv
`timescale 1ns/1ps
module test_serial_probe_cache;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int OFF_W  = 2;
    localparam int LINES  = 16;
    localparam int WAYS   = 4;
    localparam int SETS   = LINES / WAYS;
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
    localparam int PRB_W  = $clog2(WAYS + 1);
    localparam int MEMW   = 1 << (ADDR_W - OFF_W);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic              rsp_hit;
    logic [DATA_W-1:0] rsp_rdata;
    logic [PRB_W-1:0]  rsp_probes;
    logic              mem_rd_valid;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic              mem_rd_ack = 1'b0;
    logic [DATA_W-1:0] mem_rd_data = '0;
    logic              mem_wr_valid;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [DATA_W-1:0] mem_wr_data;

    int checks = 0;
    int bad = 0;
    int rd_wait = 0;

    bit              m_valid [LINES];
    logic [TAG_W-1:0] m_tag  [LINES];
    logic [31:0]      m_data [LINES];
    int               m_rr   [SETS];
    logic [31:0]      mem    [MEMW];

    always #2.5 clk = ~clk;

    serial_probe_cache i_serial_probe_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .rsp_probes(rsp_probes),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data)
    );

    // next-level model: answers a fetch after 0..3 idle cycles
    always @(negedge clk) begin
        if (mem_rd_valid && !mem_rd_ack) begin
            if (rd_wait == 0) begin
                mem_rd_ack  <= 1'b1;
                mem_rd_data <= mem[mem_rd_addr >> OFF_W];
                rd_wait     <= int'($urandom_range(0, 3));
            end else begin
                rd_wait <= rd_wait - 1;
            end
        end else begin
            mem_rd_ack <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int tag, input int set, input int off);
        return {TAG_W'(tag), SET_W'(set), OFF_W'(off)};
    endfunction

    task automatic do_op(input logic [ADDR_W-1:0] a, input bit w,
                         input logic [31:0] wd, input string rq);
        int set = int'(a[OFF_W +: SET_W]);
        logic [TAG_W-1:0] tag = a[ADDR_W-1 -: TAG_W];
        bit exp_hit = 0;
        int exp_pr = WAYS;
        int inv = -1;
        int hidx = 0;
        logic [31:0] exp_rd;
        int lat;
        for (int i = 0; i < WAYS; i++) begin
            int idx = i * SETS + set;
            if (!exp_hit) begin
                if (m_valid[idx] && m_tag[idx] == tag) begin
                    exp_hit = 1; exp_pr = i + 1; hidx = idx;
                end else if (!m_valid[idx] && inv < 0) begin
                    inv = i;
                end
            end
        end
        exp_rd = exp_hit ? m_data[hidx] : mem[a >> OFF_W];
        if (!w && !exp_hit) begin
            int way = (inv >= 0) ? inv : m_rr[set];
            int fi = way * SETS + set;
            if (inv < 0) m_rr[set] = (m_rr[set] + 1) % WAYS;
            m_valid[fi] = 1; m_tag[fi] = tag; m_data[fi] = mem[a >> OFF_W];
        end
        if (w && exp_hit) m_data[hidx] = wd;

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid) begin
            @(negedge clk);
            lat++;
        end
        chk(rsp_hit == exp_hit, rq, "hit", rsp_hit, exp_hit);
        chk(int'(rsp_probes) == exp_pr, rq, "probes", rsp_probes, exp_pr);
        if (exp_hit)
            chk(lat == exp_pr + 1, "R3", "latency", lat, exp_pr + 1);
        if (!w)
            chk(rsp_rdata == exp_rd, rq, "rdata", rsp_rdata, exp_rd);
        chk(mem_wr_valid == w, w ? "R8" : "R10", "wr_valid", mem_wr_valid, w);
        if (w) begin
            chk(mem_wr_addr == a, exp_hit ? "R8" : "R9", "wr_addr", mem_wr_addr, a);
            chk(mem_wr_data == wd, exp_hit ? "R8" : "R9", "wr_data", mem_wr_data, wd);
            mem[a >> OFF_W] = wd;
        end
        @(negedge clk);
        chk(!rsp_valid, "R10", "pulse", rsp_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < MEMW; i++) mem[i] = 32'(i) * 32'h9E3779B1 ^ 32'h0BADF00D;
        for (int i = 0; i < LINES; i++) begin m_valid[i] = 0; m_tag[i] = '0; m_data[i] = '0; end
        for (int s = 0; s < SETS; s++) m_rr[s] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
        chk(mem_rd_valid == 1'b0, "R1", "mem_rd_valid", mem_rd_valid, 0);
        chk(mem_wr_valid == 1'b0, "R1", "mem_wr_valid", mem_wr_valid, 0);
        // R1 R5 R6: empty set fills ways 0..3 in order
        do_op(mk(1, 0, 0), 0, 0, "R1");
        do_op(mk(2, 0, 1), 0, 0, "R6");
        do_op(mk(3, 0, 2), 0, 0, "R6");
        do_op(mk(4, 0, 3), 0, 0, "R5");
        // R2 R3 R4: hits at every probe depth
        do_op(mk(1, 0, 3), 0, 0, "R3");
        do_op(mk(2, 0, 0), 0, 0, "R3");
        do_op(mk(3, 0, 1), 0, 0, "R4");
        do_op(mk(4, 0, 2), 0, 0, "R2");
        // R7: rotating victim in a full set
        do_op(mk(5, 0, 0), 0, 0, "R7");
        do_op(mk(5, 0, 1), 0, 0, "R7");
        do_op(mk(1, 0, 0), 0, 0, "R7");
        do_op(mk(2, 0, 0), 0, 0, "R7");
        do_op(mk(1, 1, 0), 0, 0, "R7");
        do_op(mk(1, 1, 2), 0, 0, "R2");
        // R8: write hit then read back
        do_op(mk(5, 0, 2), 1, 32'hCAFE0001, "R8");
        do_op(mk(5, 0, 0), 0, 0, "R8");
        // R9: write miss, no allocation
        do_op(mk(9, 2, 1), 1, 32'h5A5A1234, "R9");
        do_op(mk(9, 2, 0), 0, 0, "R9");
        // random traffic
        for (int n = 0; n < 600; n++) begin
            bit w = ($urandom_range(0, 3) == 0);
            do_op(mk(int'($urandom_range(0, 5)), int'($urandom_range(0, SETS - 1)),
                     int'($urandom_range(0, 3))), w, $urandom, w ? "R8" : "R4");
        end
        summary();
    end

endmodule